// File: doc/BRIEF.md
# Serial DAC Update Controller

This block sits between a host write port and a two-channel serial digital-to-analog converter. The host writes 16-bit words, either whole or as a low byte followed by a high byte. Each word is parked in a holding register and then copied into a shift register. From there it is sent most significant bit first on a serial clock derived from the system clock. The top four bits of a word choose the target channel, and the lower twelve bits carry a right-justified two's-complement sample.

When a word has been fully shifted, the block pulses a load strobe for the addressed channel. A two-bit mode input decides when the converter outputs take the new values.

- In direct mode, a common update strobe follows each load strobe at once, so the channels are not aligned with each other.
- In the three synchronized modes, loaded samples wait in the converter's input registers. Both outputs then move together on one chosen event: a timer overflow pulse, a rising edge of an asynchronous gate input, or a pacer tick.

Top module: `dac_serial_ctrl`

## Requirements
- R1: While reset is asserted, `sclk`, `sdata`, `busy`, `loadStrobe` and `updateStrobe` are all 0.
- R2: A write whose `wrByteEn` is 2'b11 sends the 16-bit word on `sdata`, bit 15 first. Each bit is held for 4 clock cycles: 2 with `sclk` low, then 2 with `sclk` high. `sdata` does not change while `sclk` is high.
- R3: A write with `wrByteEn` = 2'b01 stores bits 7:0 and starts nothing. A later write with `wrByteEn` = 2'b10 stores bits 15:8 and starts the transfer of the combined word.
- R4: `busy` rises one cycle after the write that starts a transfer and stays high for exactly 64 cycles.
- R5: In the cycle `busy` falls, `loadStrobe` pulses for one cycle. Bits 15:12 = 4'h0 give 2'b01, 4'h1 gives 2'b10, and any other value gives no pulse.
- R6: In mode 2'd0, `updateStrobe` pulses for one cycle, exactly one cycle after each load strobe pulse. Timer, gate and pacer events have no effect in this mode.
- R7: In modes 2'd1 (timer) and 2'd3 (pacer), a load produces no update. A one-cycle pulse on `timerOvf` (mode 1) or `pacerTick` (mode 3) gives a one-cycle `updateStrobe` in the next cycle. The events of the other modes are ignored.
- R8: In mode 2'd2, a low-to-high change of `gateIn` passes a two-flop synchronizer and gives one `updateStrobe` pulse in the third cycle after the change. A falling `gateIn` gives nothing.
- R9: A word written while `busy` is high waits and starts in the cycle after `busy` falls. A second such write before that point replaces the waiting word, and the replaced word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrByteEn | input | 2 | Byte lanes written (bit 0 low byte, bit 1 high byte) |
| wrData | input | 16 | Host write data |
| modeSel | input | 2 | Update mode: 0 direct, 1 timer, 2 gate, 3 pacer |
| timerOvf | input | 1 | Timer overflow pulse |
| gateIn | input | 1 | Asynchronous external gate |
| pacerTick | input | 1 | Pacer clock tick pulse |
| sclk | output | 1 | Serial clock to the converter |
| sdata | output | 1 | Serial data, MSB first |
| loadStrobe | output | 2 | Per-channel input-register load pulse |
| updateStrobe | output | 1 | Common output-register update pulse |
| busy | output | 1 | High while a word is being shifted |

## Verification
Words go in whole or as byte pairs, with channel nibbles of 0, 1 and other values. This separates routing from the byte-lane assembly and from the no-strobe case. Each mode is then driven with its own event and with the events of the other modes. That shows whether the update source is chosen by the mode or leaks from another trigger. It also shows whether the gate path detects edges rather than levels. Back-to-back writes during a transfer separate queueing from overwrite.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

  typedef enum logic [1:0] {
    UPD_DIRECT = 2'd0,
    UPD_TIMER  = 2'd1,
    UPD_GATE   = 2'd2,
    UPD_PACER  = 2'd3
  } updMode_t;

  typedef struct packed {
    logic loadShift;
    logic shiftStep;
    logic finish;
  } shStrobes_t;

endpackage

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl
  import dac_ser_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 4,
  parameter int BYTES   = WORD_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BYTES-1:0] wrByteEn,
  output shStrobes_t       strobes,
  output logic             sclk,
  output logic             busy
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] LAST_PHASE = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] HIGH_PHASE = DIV_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_W - 1);

  logic             pending;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             wrHigh, startShift, lastPhase, endWord;

  // the top byte lane completes a word
  assign wrHigh     = wrEn & wrByteEn[BYTES-1];
  assign startShift = pending & ~busy;
  assign lastPhase  = (divCnt == LAST_PHASE);
  assign endWord    = busy & lastPhase & (bitCnt == LAST_BIT);

  assign strobes.loadShift = startShift;
  assign strobes.shiftStep = busy & lastPhase & ~endWord;
  assign strobes.finish    = endWord;

  assign sclk = busy & (divCnt >= HIGH_PHASE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      pending <= wrHigh | (pending & ~startShift);
      if (startShift) begin
        busy   <= 1'b1;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (busy) begin
        divCnt <= lastPhase ? '0 : divCnt + 1'b1;
        if (lastPhase) bitCnt <= bitCnt + 1'b1;
        if (endWord)   busy   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dac_ser_dp.sv
module dac_ser_dp
  import dac_ser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTES  = WORD_W / 8,
  parameter int NUM_CH = 2,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BYTES-1:0]  wrByteEn,
  input  logic [WORD_W-1:0] wrData,
  input  shStrobes_t        strobes,
  output logic              sdata,
  output logic [NUM_CH-1:0] loadStrobe
);
  logic [WORD_W-1:0] bufReg, bufNext, shReg;
  logic [CH_W-1:0]   holdChan;
  logic [NUM_CH-1:0] chanHit;

  always_comb begin
    bufNext = bufReg;
    for (int g = 0; g < BYTES; g++) begin
      if (wrEn && wrByteEn[g]) bufNext[8*g +: 8] = wrData[8*g +: 8];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanHit[c] = (holdChan == CH_W'(c));
  end

  assign sdata = shReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg     <= '0;
      shReg      <= '0;
      holdChan   <= '0;
      loadStrobe <= '0;
    end else begin
      bufReg <= bufNext;
      if (strobes.loadShift) begin
        shReg    <= bufReg;
        holdChan <= bufReg[WORD_W-1 -: CH_W];
      end else if (strobes.shiftStep) begin
        shReg <= shReg << 1;
      end else if (strobes.finish) begin
        shReg <= '0;
      end
      loadStrobe <= strobes.finish ? chanHit : '0;
    end
  end

endmodule

// File: rtl/dac_ser_trig.sv
module dac_ser_trig
  import dac_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       timerOvf,
  input  logic       gateIn,
  input  logic       pacerTick,
  input  logic       loadDone,
  output logic       updateStrobe
);
  logic [SYNC_STAGES:0] gateSync;
  logic                 gateRise, fire;
  updMode_t             mode;

  assign mode     = updMode_t'(modeSel);
  assign gateRise = gateSync[SYNC_STAGES-1] & ~gateSync[SYNC_STAGES];

  always_comb begin
    unique case (mode)
      UPD_DIRECT: fire = loadDone;
      UPD_TIMER:  fire = timerOvf;
      UPD_GATE:   fire = gateRise;
      UPD_PACER:  fire = pacerTick;
      default:    fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateSync     <= '0;
      updateStrobe <= 1'b0;
    end else begin
      gateSync     <= {gateSync[SYNC_STAGES-1:0], gateIn};
      updateStrobe <= fire;
    end
  end

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_ser_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NUM_CH      = 2,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WORD_W/8-1:0] wrByteEn,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [1:0]          modeSel,
  input  logic                timerOvf,
  input  logic                gateIn,
  input  logic                pacerTick,
  output logic                sclk,
  output logic                sdata,
  output logic [NUM_CH-1:0]   loadStrobe,
  output logic                updateStrobe,
  output logic                busy
);
  localparam int BYTES = WORD_W / 8;
  localparam int CH_W  = 4;

  shStrobes_t strobes;

  dac_ser_ctrl #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV), .BYTES(BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteEn(wrByteEn),
    .strobes(strobes), .sclk(sclk), .busy(busy)
  );

  dac_ser_dp #(.WORD_W(WORD_W), .BYTES(BYTES), .NUM_CH(NUM_CH), .CH_W(CH_W)) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
    .strobes(strobes), .sdata(sdata), .loadStrobe(loadStrobe)
  );

  dac_ser_trig #(.SYNC_STAGES(SYNC_STAGES)) i_trig (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .timerOvf(timerOvf),
    .gateIn(gateIn), .pacerTick(pacerTick), .loadDone(|loadStrobe),
    .updateStrobe(updateStrobe)
  );

endmodule

// File: rtl/dac_serial_chk.sv
module dac_serial_chk #(
  parameter int BUSY_LEN = 64,
  parameter int NUM_CH   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              timerOvf,
  input logic              sclk,
  input logic              sdata,
  input logic [NUM_CH-1:0] loadStrobe,
  input logic              updateStrobe,
  input logic              busy
);
  int busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= 0;
    else       busyLen <= busy ? busyLen + 1 : 0;
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  p_sdata_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclk) |-> $stable(sdata));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == BUSY_LEN);

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  p_strobe_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe != '0) |-> $fell(busy));

  p_direct_update_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && modeSel == 2'd0 && $past(modeSel) == 2'd0) |-> $past(loadStrobe != '0));

  p_timer_update_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 && $past(modeSel) == 2'd1) |-> updateStrobe == $past(timerOvf));

endmodule

bind dac_serial_ctrl dac_serial_chk #(.BUSY_LEN(WORD_W * CLK_DIV), .NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .timerOvf(timerOvf), .sclk(sclk),
  .sdata(sdata), .loadStrobe(loadStrobe), .updateStrobe(updateStrobe), .busy(busy)
);

// File: tb/test_dac_serial_ctrl.sv
module test_dac_serial_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrByteEn;
  logic [15:0] wrData;
  logic [1:0]  modeSel;
  logic        timerOvf, gateIn, pacerTick;
  logic        sclk, sdata, updateStrobe, busy;
  logic [1:0]  loadStrobe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dac_serial_ctrl i_dac_serial_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
    .modeSel(modeSel), .timerOvf(timerOvf), .gateIn(gateIn), .pacerTick(pacerTick),
    .sclk(sclk), .sdata(sdata), .loadStrobe(loadStrobe),
    .updateStrobe(updateStrobe), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expStrobe(input logic [15:0] w);
    case (w[15:12])
      4'h0:    return 2'b01;
      4'h1:    return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic writeWord(input logic [15:0] w, input bit asBytes);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    wrByteEn = asBytes ? 2'b01 : 2'b11;
    if (asBytes) begin
      @(negedge clk);
      wrByteEn = 2'b10;
    end
    @(negedge clk);
    wrEn = 1'b0;
    wrByteEn = 2'b00;
  endtask

  task automatic collect(output logic [15:0] word, output int nBits, output int busyN,
                         output int idleN, output logic [1:0] strobe);
    bit seen = 1'b0;
    logic prevSclk = 1'b0;
    word = '0; nBits = 0; busyN = 0; idleN = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy) begin
        seen = 1'b1;
        busyN++;
      end else if (!seen) begin
        idleN++;
      end
      if (sclk && !prevSclk) begin
        word = {word[14:0], sdata};
        nBits++;
      end
      prevSclk = sclk;
      if (seen && !busy) break;
    end
    strobe = loadStrobe;
  endtask

  task automatic runOne(input logic [15:0] w, input logic [1:0] mode, input bit asBytes);
    logic [15:0] got;
    logic [1:0]  strb;
    int nb, bn, idl;
    bit expUpd;
    modeSel = mode;
    writeWord(w, asBytes);
    collect(got, nb, bn, idl, strb);
    check(got == w, "R2", "serial word", got, w);
    check(nb == 16, "R2", "sclk rising edges", nb, 16);
    check(bn == 64, "R4", "busy length", bn, 64);
    check(idl == 0, "R4", "start delay", idl, 0);
    check(strb == expStrobe(w), "R5", "load strobe", strb, expStrobe(w));
    @(negedge clk);
    check(loadStrobe == 2'b00, "R5", "load strobe width", loadStrobe, 0);
    expUpd = (mode == 2'd0) && (expStrobe(w) != 2'b00);
    check(updateStrobe == expUpd, (mode == 2'd0) ? "R6" : "R7", "update after load",
          updateStrobe, expUpd);
    @(negedge clk);
    check(updateStrobe == 1'b0, "R6", "update width", updateStrobe, 0);
  endtask

  task automatic fireCheck(input logic [1:0] mode, input int which);
    int ones = 0;
    int pos = 0;
    int lateOnes = 0;
    bit match;
    int expPos;
    string req;
    match  = (mode != 2'd0) && (which == int'(mode));
    expPos = (which == 2) ? 3 : 1;
    req    = (mode == 2'd0) ? "R6" : ((which == 2 || mode == 2'd2) ? "R8" : "R7");
    modeSel = mode;
    @(negedge clk);
    case (which)
      1: timerOvf = 1'b1;
      2: gateIn = 1'b1;
      default: pacerTick = 1'b1;
    endcase
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      timerOvf = 1'b0;
      pacerTick = 1'b0;
      if (updateStrobe) begin
        ones++;
        pos = k;
      end
    end
    check(ones == (match ? 1 : 0), req, "update count on event", ones, match ? 1 : 0);
    if (match) check(pos == expPos, req, "update cycle", pos, expPos);
    if (which == 2) begin
      gateIn = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (updateStrobe) lateOnes++;
      end
      check(lateOnes == 0, "R8", "update on gate fall", lateOnes, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] gotA, gotC, w;
    logic [1:0]  strb, md;
    int nb, bn, idl, busyHits;
    void'($urandom(32'd20240607));
    rstN = 1'b0; wrEn = 1'b0; wrByteEn = 2'b00; wrData = '0; modeSel = 2'd0;
    timerOvf = 1'b0; gateIn = 1'b0; pacerTick = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(loadStrobe == 2'b00, "R1", "loadStrobe in reset", loadStrobe, 0);
    check(updateStrobe == 1'b0, "R1", "updateStrobe in reset", updateStrobe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // direct mode, both channels, triggers ignored (R6)
    runOne(16'h0800, 2'd0, 1'b0);
    fireCheck(2'd0, 1);
    fireCheck(2'd0, 2);
    fireCheck(2'd0, 3);
    runOne(16'h17FF, 2'd0, 1'b1);
    // other channel nibble: shifted, no strobe (R5)
    runOne(16'h5ABC, 2'd0, 1'b0);

    // R3: low byte alone starts nothing
    modeSel = 2'd1;
    @(negedge clk);
    wrEn = 1'b1; wrByteEn = 2'b01; wrData = 16'hEE34;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = 2'b00;
    busyHits = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (busy) busyHits++;
    end
    check(busyHits == 0, "R3", "busy after low byte", busyHits, 0);
    wrEn = 1'b1; wrByteEn = 2'b10; wrData = 16'h12DD;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = 2'b00;
    collect(gotA, nb, bn, idl, strb);
    check(gotA == 16'h1234, "R3", "assembled word", gotA, 16'h1234);
    check(strb == 2'b10, "R3", "assembled strobe", strb, 2'b10);

    // synchronized modes (R7, R8)
    runOne(16'h0123, 2'd1, 1'b0);
    fireCheck(2'd1, 3);
    fireCheck(2'd1, 2);
    fireCheck(2'd1, 1);
    runOne(16'h1F00, 2'd2, 1'b0);
    fireCheck(2'd2, 1);
    fireCheck(2'd2, 3);
    fireCheck(2'd2, 2);
    runOne(16'h0FFF, 2'd3, 1'b1);
    fireCheck(2'd3, 1);
    fireCheck(2'd3, 2);
    fireCheck(2'd3, 3);

    // R9: queue during busy, later write overwrites pending
    modeSel = 2'd1;
    @(negedge clk);
    wrEn = 1'b1; wrByteEn = 2'b11; wrData = 16'h0A5A;
    @(negedge clk);
    wrData = 16'h1BBB;
    @(negedge clk);
    wrData = 16'h1C3C;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = 2'b00;
    collect(gotA, nb, bn, idl, strb);
    check(gotA == 16'h0A5A, "R9", "first word", gotA, 16'h0A5A);
    collect(gotC, nb, bn, idl, strb);
    check(gotC == 16'h1C3C, "R9", "overwriting word", gotC, 16'h1C3C);
    check(idl == 0, "R9", "queued start delay", idl, 0);
    check(bn == 64, "R9", "queued busy length", bn, 64);
    busyHits = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (busy) busyHits++;
    end
    check(busyHits == 0, "R9", "overwritten word not sent", busyHits, 0);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      w = 16'($urandom);
      case ($urandom_range(0, 3))
        0: w[15:12] = 4'h0;
        1: w[15:12] = 4'h1;
        default: ;
      endcase
      md = 2'($urandom_range(0, 3));
      runOne(w, md, 1'($urandom_range(0, 1)));
      fireCheck(md, int'($urandom_range(1, 3)));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule